// File: doc/BRIEF.md
# Dual-Width Condition-Code ALU

A purely combinational integer execution unit for a 64-bit datapath. Each operation produces a 64-bit result and a new condition byte. One half of that byte holds flags for the low 32 bits of the result, and the other half holds flags for the full 64 bits, so software of either width can branch on the same operation without a second pass. The unit covers add and subtract, with or without an incoming carry or borrow. It also covers six bitwise operations that update the flags only on request, tagged add and subtract with an optional trap, and a one-bit multiply step that consumes and shifts a 32-bit auxiliary register (Y).

The surrounding pipeline supplies two operands, an operation code, a flag-update request, the current condition byte and Y. It takes back the result, the next condition byte, the next Y, a register write enable and a tag-overflow fault. Operation codes (`op`): 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 and, 5 or, 6 xor, 7 and-not (rs1 & ~rs2), 8 or-not (rs1 | ~rs2), 9 xnor, 10 tagged add, 11 tagged subtract, 12 tagged add with trap, 13 tagged subtract with trap, 14 multiply step, 15 reserved.

Top module: `dwcc_alu`

## Requirements
- R1: `cc_out[3:0]` holds the 32-bit flags and `cc_out[7:4]` the 64-bit flags. Each nibble is ordered {N, Z, V, C} from bit 3 down to bit 0. N is result bit 31 (low nibble) or bit 63 (high nibble). Z is set when result[31:0] (low nibble) or the whole result (high nibble) is zero.
- R2: Add (op 0) returns rs1 + rs2 modulo 2^64. C is the unsigned carry out of bit 31 or bit 63. V is set when the operands share a sign bit and the result sign differs from it.
- R3: Subtract (op 2) returns rs1 - rs2. C is set when an unsigned borrow occurs at 32 or 64 bits. V is set when the operand signs differ and the result sign differs from rs1.
- R4: Add-with-carry (op 1) adds `cc_in[0]`, and subtract-with-borrow (op 3) also subtracts `cc_in[0]`. Both produce flags under the R2/R3 rules applied to the complete operation.
- R5: Ops 4 to 9 return the bitwise function of rs1 and rs2. With `set_flags`=1, both nibbles get N and Z from the result and V = C = 0.
- R6: For ops 0 to 9 with `set_flags`=0, `cc_out` equals `cc_in`, while the result is still produced and written.
- R7: Tagged add and subtract (ops 10, 11) always update flags using the R2/R3 rules. They also set the 32-bit V whenever rs1[1:0] or rs2[1:0] is nonzero. They never fault.
- R8: Trapping tagged ops (12, 13) assert `tag_fault` exactly when the 32-bit V of R7 would be set. On a fault, `wr_en`=0 and `cc_out`=`cc_in`. Without a fault they behave as ops 10, 11.
- R9: Multiply step (op 14) adds the zero-extended 32-bit value {N^V of `cc_in[3:0]`, rs1[31:1]} to rs2 when `y_in[0]`=1, and to zero otherwise. Flags always update under the R2 rules applied to that addition.
- R10: Multiply step returns `y_out` = {rs1[0], y_in[31:1]}. Every other op returns `y_out` = `y_in`.
- R11: Reserved op 15 gives result 0, `wr_en`=0, `tag_fault`=0 and `cc_out`=`cc_in`.
- R12: `wr_en` is 1 for every op 0 to 14 unless `tag_fault` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1 | input | 64 | First operand |
| rs2 | input | 64 | Second operand (register or immediate, already selected) |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Request flag update for ops 0 to 9 |
| cc_in | input | 8 | Current condition byte |
| y_in | input | 32 | Current auxiliary Y register |
| result | output | 64 | Operation result |
| cc_out | output | 8 | Next condition byte |
| y_out | output | 32 | Next Y register |
| wr_en | output | 1 | Destination register write enable |
| tag_fault | output | 1 | Tag-overflow trap request |

## Verification
The two functions that collide are the trapping tagged check and the flag update. A trapping tagged operation computes a complete new condition byte, but that byte must be discarded whenever its own 32-bit V raises the fault. The bench provokes this three ways: with tag bits set in one operand, with a plain signed overflow and clean tag bits, and with both conditions together. Each time it judges that `cc_out` equals a distinctive `cc_in` and `wr_en` falls in the same cycle that `tag_fault` rises. A second overlap is the multiply step, which updates flags from a partial product built from the old flags and shifts Y in the same operation. The bench checks both outputs together with `y_in[0]` at each value.

// File: rtl/dwcc_pkg.sv
package dwcc_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_ORN   = 4'd8,
    OP_XNOR  = 4'd9,
    OP_TADD  = 4'd10,
    OP_TSUB  = 4'd11,
    OP_TADDT = 4'd12,
    OP_TSUBT = 4'd13,
    OP_MSTEP = 4'd14,
    OP_RSVD  = 4'd15
  } dw_op_e;

  // flag nibble layout {N, Z, V, C}
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;

  function automatic logic [3:0] make_nib(input logic n, input logic z,
                                          input logic v, input logic c);
    return {n, z, v, c};
  endfunction

  // overflow rule on an adder whose second input is already inverted for subtract
  function automatic logic sign_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/dwcc_adder.sv
module dwcc_adder #(
  parameter int DATA_W = 64,
  localparam int LOW_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic [3:0]        nib_lo,
  output logic [3:0]        nib_hi
);
  import dwcc_pkg::*;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   full_sum;
  logic [LOW_W:0]    low_sum;
  logic              carry_lo, carry_hi;

  always_comb begin
    b_eff    = sub ? ~b : b;
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    low_sum  = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
    sum      = full_sum[DATA_W-1:0];
    // inverted carry acts as a borrow for subtraction
    carry_lo = low_sum[LOW_W] ^ sub;
    carry_hi = full_sum[DATA_W] ^ sub;
    nib_lo = make_nib(sum[LOW_W-1], ~|sum[LOW_W-1:0],
                      sign_ovf(a[LOW_W-1], b_eff[LOW_W-1], sum[LOW_W-1]), carry_lo);
    nib_hi = make_nib(sum[DATA_W-1], ~|sum,
                      sign_ovf(a[DATA_W-1], b_eff[DATA_W-1], sum[DATA_W-1]), carry_hi);
  end

endmodule

// File: rtl/dwcc_logic.sv
module dwcc_logic #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        sel,
  output logic [DATA_W-1:0] res
);
  import dwcc_pkg::*;

  always_comb begin
    unique case (dw_op_e'(sel))
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ANDN: res = a & ~b;
      OP_ORN:  res = a | ~b;
      OP_XNOR: res = ~(a ^ b);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/dwcc_mstep.sv
module dwcc_mstep #(
  parameter int DATA_W = 64,
  localparam int LOW_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  input  logic [3:0]        flags_lo,
  input  logic [LOW_W-1:0]  y_in,
  output logic [DATA_W-1:0] part_a,
  output logic [DATA_W-1:0] part_b,
  output logic [LOW_W-1:0]  y_next
);
  import dwcc_pkg::*;

  logic nv_bit;

  always_comb begin
    nv_bit = flags_lo[FN] ^ flags_lo[FV];
    part_a = {{(DATA_W-LOW_W){1'b0}}, nv_bit, rs1[LOW_W-1:1]};
    part_b = y_in[0] ? rs2 : '0;
    y_next = {rs1[0], y_in[LOW_W-1:1]};
  end

endmodule

// File: rtl/dwcc_alu.sv
module dwcc_alu #(
  parameter int DATA_W = 64,
  localparam int LOW_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  input  logic [3:0]        op,
  input  logic              set_flags,
  input  logic [7:0]        cc_in,
  input  logic [LOW_W-1:0]  y_in,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        cc_out,
  output logic [LOW_W-1:0]  y_out,
  output logic              wr_en,
  output logic              tag_fault
);
  import dwcc_pkg::*;

  dw_op_e            opc;
  logic              is_arith, is_logic, is_tag, is_trapv, is_mstep, is_rsvd, is_sub;
  logic [DATA_W-1:0] add_a, add_b, add_sum, logic_res, ms_a, ms_b;
  logic              add_cin;
  logic [3:0]        nib_lo, nib_hi;
  logic [LOW_W-1:0]  ms_y;
  logic              tag_bits, tag_v32, flag_update;
  logic [7:0]        flags_new;

  always_comb begin
    opc      = dw_op_e'(op);
    is_arith = opc inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC};
    is_logic = opc inside {OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_XNOR};
    is_tag   = opc inside {OP_TADD, OP_TSUB, OP_TADDT, OP_TSUBT};
    is_trapv = opc inside {OP_TADDT, OP_TSUBT};
    is_mstep = (opc == OP_MSTEP);
    is_rsvd  = (opc == OP_RSVD);
    is_sub   = opc inside {OP_SUB, OP_SUBC, OP_TSUB, OP_TSUBT};
    add_a    = is_mstep ? ms_a : rs1;
    add_b    = is_mstep ? ms_b : rs2;
    unique case (opc)
      OP_ADDC:                   add_cin = cc_in[FC];
      OP_SUBC:                   add_cin = ~cc_in[FC];
      OP_SUB, OP_TSUB, OP_TSUBT: add_cin = 1'b1;
      default:                   add_cin = 1'b0;
    endcase
  end

  dwcc_adder #(.DATA_W(DATA_W)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin), .sub(is_sub),
    .sum(add_sum), .nib_lo(nib_lo), .nib_hi(nib_hi)
  );

  dwcc_logic #(.DATA_W(DATA_W)) u_logic (
    .a(rs1), .b(rs2), .sel(op), .res(logic_res)
  );

  dwcc_mstep #(.DATA_W(DATA_W)) u_mstep (
    .rs1(rs1), .rs2(rs2), .flags_lo(cc_in[3:0]), .y_in(y_in),
    .part_a(ms_a), .part_b(ms_b), .y_next(ms_y)
  );

  always_comb begin
    tag_bits  = (|rs1[1:0]) | (|rs2[1:0]);
    tag_v32   = nib_lo[FV] | tag_bits;
    tag_fault = is_trapv & tag_v32;

    if (is_logic) begin
      result    = logic_res;
      flags_new = {make_nib(logic_res[DATA_W-1], ~|logic_res, 1'b0, 1'b0),
                   make_nib(logic_res[LOW_W-1], ~|logic_res[LOW_W-1:0], 1'b0, 1'b0)};
    end else if (is_rsvd) begin
      result    = '0;
      flags_new = cc_in;
    end else begin
      result    = add_sum;
      flags_new = {nib_hi, nib_lo[FN], nib_lo[FZ], is_tag ? tag_v32 : nib_lo[FV], nib_lo[FC]};
    end

    flag_update = ((is_tag | is_mstep) | ((is_arith | is_logic) & set_flags)) & ~tag_fault;
    cc_out      = flag_update ? flags_new : cc_in;
    wr_en       = ~is_rsvd & ~tag_fault;
    y_out       = is_mstep ? ms_y : y_in;
  end

  // checks between the separately built pieces
  always_comb begin
    AST_TRAP_HOLDS_STATE: assert (!tag_fault || (!wr_en && cc_out == cc_in)) else $error("fault with write or flag change"); // R8
    AST_TAG_SETS_V: assert (!(is_tag && tag_bits && !tag_fault) || cc_out[FV]) else $error("tag bits without V"); // R7
    AST_Y_UNTOUCHED: assert (is_mstep || y_out == y_in) else $error("Y changed by non-step op"); // R10
    AST_LOGIC_VC_CLEAR: assert (!(is_logic && set_flags) || (cc_out[1:0] == 2'b00 && cc_out[5:4] == 2'b00)) else $error("logic op left V/C"); // R5
    AST_Z_TRACKS_RESULT: assert (!flag_update || is_rsvd || (cc_out[FZ] == (result[LOW_W-1:0] == '0) && cc_out[4+FZ] == (result == '0))) else $error("Z disagrees with result"); // R1
    AST_RSVD_QUIET: assert (!is_rsvd || (!wr_en && !tag_fault && cc_out == cc_in)) else $error("reserved op acted"); // R11
  end

endmodule

// File: tb/sim_dwcc_alu.sv
module sim_dwcc_alu;

  typedef struct {
    logic [3:0]  op;
    logic [63:0] r;
    logic [7:0]  cc;
    logic [31:0] y;
    logic        we;
    logic        flt;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] rs1 = '0, rs2 = '0;
  logic [3:0]  op = '0;
  logic        set_flags = 1'b1;
  logic [7:0]  cc_in = '0;
  logic [31:0] y_in = '0;
  logic [63:0] result;
  logic [7:0]  cc_out;
  logic [31:0] y_out;
  logic        wr_en, tag_fault;

  dwcc_alu u0 (
    .rs1(rs1), .rs2(rs2), .op(op), .set_flags(set_flags), .cc_in(cc_in), .y_in(y_in),
    .result(result), .cc_out(cc_out), .y_out(y_out), .wr_en(wr_en), .tag_fault(tag_fault)
  );

  exp_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // independent arithmetic: signed range and unsigned compare
  function automatic void ref_arith(input logic [63:0] a, input logic [63:0] b, input bit sub,
                                    input bit k, output logic [63:0] r, output logic [7:0] cc);
    logic signed [65:0] s64;
    logic signed [33:0] s32;
    logic c32, c64, v32, v64;
    if (sub) begin
      s64 = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b}) - 66'sd1 * k;
      s32 = $signed({{2{a[31]}}, a[31:0]}) - $signed({{2{b[31]}}, b[31:0]}) - 34'sd1 * k;
      c64 = ({1'b0, a} < ({1'b0, b} + 65'(k)));
      c32 = ({1'b0, a[31:0]} < ({1'b0, b[31:0]} + 33'(k)));
    end else begin
      s64 = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b}) + 66'sd1 * k;
      s32 = $signed({{2{a[31]}}, a[31:0]}) + $signed({{2{b[31]}}, b[31:0]}) + 34'sd1 * k;
      c64 = (({1'b0, a} + {1'b0, b} + 65'(k)) > 65'h0_FFFF_FFFF_FFFF_FFFF);
      c32 = (({1'b0, a[31:0]} + {1'b0, b[31:0]} + 33'(k)) > 33'h0_FFFF_FFFF);
    end
    v64 = (s64 > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (s64 < -66'sh0_8000_0000_0000_0000);
    v32 = (s32 > 34'sh0_7FFF_FFFF) || (s32 < -34'sh0_8000_0000);
    r = s64[63:0];
    cc = {r[63], r == 64'd0, v64, c64, r[31], r[31:0] == 32'd0, v32, c32};
  endfunction

  function automatic exp_t ref_model(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                                     input bit sf, input logic [7:0] ci, input logic [31:0] yi);
    exp_t e;
    logic [63:0] r;
    logic [7:0] cc;
    e.op = o; e.y = yi; e.we = 1'b1; e.flt = 1'b0; e.cc = ci; e.r = '0;
    case (o)
      4'd0, 4'd1: begin ref_arith(a, b, 1'b0, (o == 4'd1) && ci[0], r, cc);
        e.r = r; if (sf) e.cc = cc; e.tag = (o == 4'd0) ? "R2" : "R4"; end
      4'd2, 4'd3: begin ref_arith(a, b, 1'b1, (o == 4'd3) && ci[0], r, cc);
        e.r = r; if (sf) e.cc = cc; e.tag = (o == 4'd2) ? "R3" : "R4"; end
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
        case (o)
          4'd4: r = a & b;   4'd5: r = a | b;   4'd6: r = a ^ b;
          4'd7: r = a & ~b;  4'd8: r = a | ~b;  default: r = ~(a ^ b);
        endcase
        e.r = r;
        if (sf) e.cc = {r[63], r == 64'd0, 2'b00, r[31], r[31:0] == 32'd0, 2'b00};
        e.tag = sf ? "R5" : "R6";
      end
      4'd10, 4'd11, 4'd12, 4'd13: begin
        ref_arith(a, b, o[0], 1'b0, r, cc);
        if (a[1:0] != 2'b00 || b[1:0] != 2'b00) cc[1] = 1'b1;
        e.r = r;
        if (o >= 4'd12 && cc[1]) begin e.flt = 1'b1; e.we = 1'b0; end
        else e.cc = cc;
        e.tag = (o >= 4'd12) ? "R8" : "R7";
      end
      4'd14: begin
        ref_arith({32'd0, ci[3] ^ ci[1], a[31:1]}, yi[0] ? b : 64'd0, 1'b0, 1'b0, r, cc);
        e.r = r; e.cc = cc; e.y = {a[0], yi[31:1]}; e.tag = "R9";
      end
      default: begin e.we = 1'b0; e.tag = "R11"; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input bit sf, input logic [7:0] ci, input logic [31:0] yi);
    @(posedge clk);
    #1;
    op = o; rs1 = a; rs2 = b; set_flags = sf; cc_in = ci; y_in = yi;
    sb_q.push_back(ref_model(o, a, b, sf, ci, yi));
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: one item per cycle, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "result", result, e.r);
        cmp(e.tag, "cc_out", {56'd0, cc_out}, {56'd0, e.cc});
        cmp((e.op == 4'd14) ? "R10" : e.tag, "y_out", {32'd0, y_out}, {32'd0, e.y});
        cmp((e.op == 4'd15 || e.flt) ? e.tag : "R12", "wr_en", {63'd0, wr_en}, {63'd0, e.we});
        cmp(e.tag, "tag_fault", {63'd0, tag_fault}, {63'd0, e.flt});
      end
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset-like all-zero add, both Z flags set (cc 8'h44)
    drive(4'd0, 64'd0, 64'd0, 1'b1, 8'h00, 32'd0);
    // R2: 32-bit signed overflow only; full carry wrap
    drive(4'd0, 64'h7FFF_FFFF, 64'd1, 1'b1, 8'h00, 32'd0);
    drive(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 8'h00, 32'd0);
    drive(4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 8'h00, 32'd0);
    // R3: borrow and signed overflow of subtract
    drive(4'd2, 64'd5, 64'd7, 1'b1, 8'h00, 32'd0);
    drive(4'd2, 64'h8000_0000, 64'd1, 1'b1, 8'hFF, 32'd0);
    drive(4'd2, 64'd9, 64'd9, 1'b1, 8'h00, 32'd0);
    // R4: carry and borrow in from cc_in[0]
    drive(4'd1, 64'hFFFF_FFFF, 64'd0, 1'b1, 8'h01, 32'd0);
    drive(4'd3, 64'd0, 64'd0, 1'b1, 8'h01, 32'd0);
    drive(4'd3, 64'd3, 64'd1, 1'b1, 8'h00, 32'd0);
    // R5 / R6: logic with and without flag update
    for (int k = 4; k <= 9; k++) begin
      drive(4'(k), 64'hF0F0_0000_FFFF_0001, 64'h0FF0_0000_FFFF_0001, 1'b1, 8'h33, 32'd0);
      drive(4'(k), 64'hF0F0_0000_FFFF_0001, 64'h0FF0_0000_FFFF_0001, 1'b0, 8'hA5, 32'd0);
    end
    drive(4'd0, 64'd1, 64'd2, 1'b0, 8'h5A, 32'd0);
    // R7: tag bits force V, no fault
    drive(4'd10, 64'd1, 64'd4, 1'b1, 8'h00, 32'd0);
    drive(4'd11, 64'd8, 64'd6, 1'b1, 8'h00, 32'd0);
    // R8: trap on tag bits, on pure overflow, on both; no trap when clean
    drive(4'd12, 64'd4, 64'd2, 1'b1, 8'hC3, 32'd0);
    drive(4'd12, 64'h7FFF_FFFC, 64'd4, 1'b1, 8'h96, 32'd0);
    drive(4'd13, 64'h8000_0001, 64'd4, 1'b1, 8'h69, 32'd0);
    drive(4'd13, 64'd16, 64'd8, 1'b1, 8'hFF, 32'd0);
    // R9 / R10: multiply step with Y[0] both ways and N^V set
    drive(4'd14, 64'h0000_0000_0000_0005, 64'h0000_0001_0000_0003, 1'b0, 8'h08, 32'h8000_0001);
    drive(4'd14, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1234, 1'b0, 8'h0A, 32'h0000_0002);
    drive(4'd14, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 1'b0, 8'h02, 32'hFFFF_FFFF);
    // R11: reserved op
    drive(4'd15, 64'h1234_5678, 64'h9ABC, 1'b1, 8'h7E, 32'hDEAD_BEEF);
    // broad sweep, R12 on every item
    seed = 32'd17;
    void'($urandom(seed));
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (i % 5 == 0) begin a[1:0] = 2'b00; b[1:0] = 2'b00; end
      if (i % 7 == 0) b = 64'd0;
      drive(4'($urandom() % 16), a, b, 1'($urandom()), 8'($urandom()), $urandom());
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule